// File: doc/BRIEF.md
# Locked-Rotor Retry Protection Timer

This block guards a brushless fan or pump motor against a locked rotor. While the motor is meant to turn, it watches the rising edges of one Hall sensor phase. The drive is granted in windows that are counted in prescaled timebase ticks. Each rising edge on the watched phase restarts the window, so a motor that turns never reaches the end of it. If a full window passes with no rising edge, the block withdraws permission for the high-side switches. It then waits through a rest window fifteen times as long and grants drive again. This repeats until rotation comes back.

The same timebase counter first serves as a power-up initial reset. During that time every output stage, high side and low side, must stay off. The block also passes on a speed-feedback signal that follows the watched Hall phase at the same frequency. The run enable input puts the block into a stopped state: drive is withheld, and re-enabling starts a fresh drive window. All pins are plain control levels. No data flows through the block, so it has no valid/ready handshake.

Top module: `stall_retry_timer`

## Requirements
- R1: After reset is released, init_reset_active is 1 and drive_allow is 0 until INIT_TICKS ticks have been counted.
- R2: The tick that completes the initial reset clears init_reset_active and, with run_en at 1, raises drive_allow in the same clock update.
- R3: In the drive window, drive_allow falls in the clock update of the ON_TICKS-th tick counted with no rising edge of hall_ph1 in between.
- R4: A 0-to-1 transition of hall_ph1 restarts the drive window. A 1-to-0 transition does not restart it.
- R5: The rest window lasts exactly 15*ON_TICKS ticks. drive_allow returns to 1 in the clock update of the last of those ticks, and a new drive window starts.
- R6: Edges on hall_ph1 during the rest window have no effect on drive_allow and do not shorten the rest window.
- R7: The retry protection acts only on the high side. init_reset_active stays 0 in the rest window, and once it has fallen it never rises again without a reset.
- R8: fg equals hall_ph1 delayed by two clock cycles (two synchronizer stages), in every state.
- R9: With run_en at 0, drive_allow is 0 from the next clock update and ticks have no effect. When run_en returns to 1, drive_allow is 1 from the next update, and a full ON_TICKS window follows.
- R10: drive_allow and init_reset_active are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Prescaled timebase strobe, one cycle wide |
| hall_ph1 | input | 1 | Watched Hall phase, asynchronous |
| run_en | input | 1 | Run request; 0 selects the stopped state |
| drive_allow | output | 1 | High-side drive permitted |
| init_reset_active | output | 1 | Initial reset in progress; all output stages off |
| fg | output | 1 | Speed feedback that follows hall_ph1 |

## Verification
Every decision is registered once. A tick, or a change of run_en, shows on drive_allow and init_reset_active in the same clock update that samples it. A change on hall_ph1 needs two updates to reach fg and to restart the window. The bench changes inputs on falling clock edges and samples outputs on falling edges. It holds hall_ph1 steady for three cycles before the next tick, so each restart is settled before it matters. Window boundaries are checked one tick before and exactly at the expected tick count.

// File: rtl/stall_retry_pkg.sv
package stall_retry_pkg;
  typedef enum logic [1:0] {
    PH_INIT = 2'd0,
    PH_DRIVE = 2'd1,
    PH_REST = 2'd2,
    PH_HALT = 2'd3
  } phase_t;

  localparam int unsigned REST_RATIO = 15;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/hall_edge_sync.sv
module hall_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic level_out,
  output logic rise_pulse
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= async_in;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign level_out  = chain[STAGES-1];
  assign rise_pulse = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/tick_window.sv
module tick_window #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] span,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q;

  assign expire = tick & ~clr & (cnt_q == span - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clr || expire)  cnt_q <= '0;
    else if (tick)           cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/retry_ctrl.sv
module retry_ctrl
  import stall_retry_pkg::*;
#(
  parameter int unsigned CNT_W      = 8,
  parameter int unsigned INIT_TICKS = 5,
  parameter int unsigned ON_TICKS   = 8,
  parameter int unsigned OFF_TICKS  = 120
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             hall_rise,
  input  logic             expire,
  output logic             win_clr,
  output logic [CNT_W-1:0] span,
  output logic             drive_allow,
  output logic             init_active
);
  phase_t ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    unique case (ph_q)
      PH_INIT:  if (expire) ph_d = run_en ? PH_DRIVE : PH_HALT;
      PH_DRIVE: if (!run_en) ph_d = PH_HALT;
                else if (expire) ph_d = PH_REST;
      PH_REST:  if (!run_en) ph_d = PH_HALT;
                else if (expire) ph_d = PH_DRIVE;
      PH_HALT:  if (run_en) ph_d = PH_DRIVE;
      default:  ph_d = PH_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_INIT;
    else        ph_q <= ph_d;
  end

  always_comb begin
    unique case (ph_q)
      PH_INIT:  span = CNT_W'(INIT_TICKS);
      PH_REST:  span = CNT_W'(OFF_TICKS);
      default:  span = CNT_W'(ON_TICKS);
    endcase
  end

  assign win_clr     = (ph_q == PH_HALT) | ((ph_q == PH_DRIVE) & hall_rise);
  assign drive_allow = (ph_q == PH_DRIVE);
  assign init_active = (ph_q == PH_INIT);
endmodule

// File: rtl/stall_retry_timer.sv
module stall_retry_timer
  import stall_retry_pkg::*;
#(
  parameter int unsigned INIT_TICKS  = 5,
  parameter int unsigned ON_TICKS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic hall_ph1,
  input  logic run_en,
  output logic drive_allow,
  output logic init_reset_active,
  output logic fg
);
  localparam int unsigned OFF_TICKS = REST_RATIO * ON_TICKS;
  localparam int unsigned MAX_SPAN  = max_u(OFF_TICKS, INIT_TICKS);
  localparam int unsigned CNT_W     = $clog2(MAX_SPAN + 1);

  logic             hall_rise;
  logic             win_clr;
  logic             expire;
  logic [CNT_W-1:0] span;

  hall_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .async_in  (hall_ph1),
    .level_out (fg),
    .rise_pulse(hall_rise)
  );

  tick_window #(.CNT_W(CNT_W)) u_win (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (win_clr),
    .tick  (tick),
    .span  (span),
    .expire(expire)
  );

  retry_ctrl #(
    .CNT_W     (CNT_W),
    .INIT_TICKS(INIT_TICKS),
    .ON_TICKS  (ON_TICKS),
    .OFF_TICKS (OFF_TICKS)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_en     (run_en),
    .hall_rise  (hall_rise),
    .expire     (expire),
    .win_clr    (win_clr),
    .span       (span),
    .drive_allow(drive_allow),
    .init_active(init_reset_active)
  );
endmodule

// File: rtl/stall_retry_checker.sv
module stall_retry_checker (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic hall_ph1,
  input logic run_en,
  input logic drive_allow,
  input logic init_reset_active,
  input logic fg
);
  logic [1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_allow && init_reset_active));

  assert_init_once_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(init_reset_active));

  assert_halt_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !drive_allow);

  assert_fg_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2) |-> (fg == $past(hall_ph1, 2)));

  assert_rest_needs_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!drive_allow && !init_reset_active && run_en && $past(run_en) && !tick)
      |=> !drive_allow);

  assert_grant_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_allow) |-> ($past(tick) || !$past(run_en, 2)));
endmodule

bind stall_retry_timer stall_retry_checker u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .tick             (tick),
  .hall_ph1         (hall_ph1),
  .run_en           (run_en),
  .drive_allow      (drive_allow),
  .init_reset_active(init_reset_active),
  .fg               (fg)
);

// File: tb/tb_stall_retry_timer.sv
module tb_stall_retry_timer;
  localparam int unsigned INIT_T = 5;
  localparam int unsigned ON_T   = 8;
  localparam int unsigned OFF_T  = 15 * ON_T;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic hall = 1'b0;
  logic run_en = 1'b1;
  logic drive_allow, init_reset_active, fg;
  int   n_checks = 0;
  int   n_fail = 0;

  always #5 clk = ~clk;

  stall_retry_timer #(.INIT_TICKS(INIT_T), .ON_TICKS(ON_T)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .hall_ph1(hall), .run_en(run_en),
    .drive_allow(drive_allow), .init_reset_active(init_reset_active), .fg(fg)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick = 1'b1;
      @(negedge clk) tick = 1'b0;
    end
  endtask

  task automatic hall_pulse();
    @(negedge clk) hall = 1'b1;
    repeat (3) @(negedge clk);
    hall = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset_init();
    check("R1 init after reset", init_reset_active, 1'b1);
    check("R1 drive off in reset", drive_allow, 1'b0);
    rst_n = 1'b1;
    ticks(INIT_T - 1);
    check("R1 init held", init_reset_active, 1'b1);
    check("R1 drive held off", drive_allow, 1'b0);
    ticks(1);
    check("R2 init ends", init_reset_active, 1'b0);
    check("R2 drive granted", drive_allow, 1'b1);
  endtask

  task automatic t_stall_timeout();
    ticks(ON_T - 1);
    check("R3 still driving", drive_allow, 1'b1);
    ticks(1);
    check("R3 timeout drops drive", drive_allow, 1'b0);
    check("R7 init stays low in rest", init_reset_active, 1'b0);
  endtask

  task automatic t_rest_window();
    for (int i = 0; i < OFF_T - 1; i++) begin
      ticks(1);
      if (i % 20 == 3) hall_pulse();
    end
    check("R6 edges ignored in rest", drive_allow, 1'b0);
    check("R7 init low in rest", init_reset_active, 1'b0);
    ticks(1);
    check("R5 retry after rest", drive_allow, 1'b1);
  endtask

  task automatic t_rotation();
    for (int r = 0; r < 6; r++) begin
      ticks(ON_T - 1);
      hall_pulse();
    end
    check("R4 rising edges keep drive", drive_allow, 1'b1);
    ticks(ON_T - 1);
    check("R4 window restarted by edge", drive_allow, 1'b1);
    @(negedge clk) hall = 1'b1;
    repeat (3) @(negedge clk);
    ticks(ON_T - 1);
    hall = 1'b0;
    repeat (3) @(negedge clk);
    check("R4 before falling-edge test", drive_allow, 1'b1);
    ticks(1);
    check("R4 falling edge no restart", drive_allow, 1'b0);
    ticks(OFF_T);
    check("R5 second retry", drive_allow, 1'b1);
  endtask

  task automatic t_fg();
    @(negedge clk) hall = 1'b1;
    @(negedge clk);
    check("R8 fg one cycle", fg, 1'b0);
    @(negedge clk);
    check("R8 fg two cycles", fg, 1'b1);
    hall = 1'b0;
    @(negedge clk);
    check("R8 fg fall one cycle", fg, 1'b1);
    @(negedge clk);
    check("R8 fg fall two cycles", fg, 1'b0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_run_enable();
    @(negedge clk) run_en = 1'b0;
    @(negedge clk);
    check("R9 stop drops drive", drive_allow, 1'b0);
    ticks(OFF_T + 3);
    check("R9 ticks ignored when stopped", drive_allow, 1'b0);
    t_fg();
    @(negedge clk) run_en = 1'b1;
    @(negedge clk);
    check("R9 restart grants drive", drive_allow, 1'b1);
    ticks(ON_T - 1);
    check("R9 fresh window", drive_allow, 1'b1);
    ticks(1);
    check("R9 fresh window ends", drive_allow, 1'b0);
    ticks(OFF_T / 2);
    @(negedge clk) run_en = 1'b0;
    @(negedge clk) run_en = 1'b1;
    @(negedge clk);
    check("R9 stop aborts rest", drive_allow, 1'b1);
    check("R10 exclusive", init_reset_active, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_init();
    t_fg();
    t_stall_timeout();
    t_rest_window();
    t_rotation();
    t_run_enable();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    #2000000;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule